// File: doc/BRIEF.md
# Boot Strap Latch and Reset Sequencer

This block holds the boot configuration that the device samples from its strap pins. It also decides, for each kind of reset, whether the boot flow starts at all. Four reset requests come in: power-on, full, normal and local. When two or more overlap, the strongest one governs. When the last request drops, the block does one of four things:

- It captures the synchronized strap pins into a 13-bit status word.
- It keeps the status word that was captured earlier.
- It starts nothing.
- It sends the boot flow to a saved resume address when a hibernation flag is set.

The status word is split into a boot-device code, a device-specific configuration field and a 3-bit top field. The meaning of the top field depends on the boot device. For the two serial-memory devices the clock multiplier is bypassed, and the top field is reported as extended configuration. For every other device the top field selects the clock-multiplier setting. Downstream boot logic uses the one-cycle boot-start pulse, the resume request and the decoded fields.

Top module: `boot_strap_seq`

## Requirements
- R1: The status word keeps the boot device in bits [2:0], the device configuration in bits [9:3] and the top field in bits [12:10]. The decoded outputs show exactly these slices.
- R2: When a power-on request is released, the strap value synchronized at that edge is captured into the status word.
- R3: When a full-reset request is released, the strap value is captured the same way as for power-on.
- R4: When a normal-reset request is released, the boot flow starts and the status word keeps its previous value.
- R5: When a local-reset request is released, the status word is unchanged and neither the boot-start pulse nor the resume request is raised.
- R6: The boot-start pulse is high for exactly one cycle. It rises on the first clock edge at which no reset request is sampled high.
- R7: The bypass flag is 1 exactly when the boot device code is 5 (I2C) or 6 (SPI). Codes 0, 1, 2, 3, 4 and 7 give 0.
- R8: When bypass is 1, the PLL-select output is 0 and the extended-configuration output carries bits [12:10]. When bypass is 0, the two outputs swap roles.
- R9: If the hibernation flag is high when a power-on, full or normal request is released, the following happens:
  - The resume request pulses for one cycle instead of boot-start.
  - The resume address output takes the value on the address input at that edge.
  - The status word is not changed.
- R10: Requests that overlap are combined by priority: power-on, then full, then normal, then local. The strongest request seen since the window opened decides what happens at release.
- R11: The asynchronous reset rst_ni clears the status word, the pulses and the resume address to 0.
- R12: Strap changes while no request is being released do not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 13 | Raw strap pins |
| por_req_i | input | 1 | Power-on reset request, high while held |
| full_req_i | input | 1 | Full reset request |
| sys_req_i | input | 1 | Normal reset request |
| core_req_i | input | 1 | Local (core-only) reset request |
| hib_i | input | 1 | Hibernation flag |
| hib_addr_i | input | 32 | Resume address for hibernation |
| status_o | output | 13 | Latched strap status word |
| boot_dev_o | output | 3 | Boot device code |
| dev_cfg_o | output | 7 | Device configuration field |
| pll_sel_o | output | 3 | Clock-multiplier select (0 when bypassed) |
| ext_cfg_o | output | 3 | Extended configuration (0 when not bypassed) |
| pll_bypass_o | output | 1 | Clock-multiplier bypass flag |
| boot_start_o | output | 1 | One-cycle boot-start pulse |
| resume_o | output | 1 | One-cycle resume-branch request |
| resume_addr_o | output | 32 | Held resume address |

## Verification
Every reset request is released at a falling edge of the clock. The first rising edge after that is the release edge. At that edge the status word is captured, and boot-start or resume rises. The decoded fields follow the status word without an added register. All of these results are therefore sampled at the falling edge right after the release edge. The pulse is sampled again one falling edge later, where it must be back at 0. The strap pins are changed at least three cycles before any release, so the two-flop synchronizer has settled before the value is expected in the status word.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;
  localparam int unsigned DEV_W  = 3;
  localparam int unsigned CFG_W  = 7;
  localparam int unsigned TOP_W  = 3;
  localparam int unsigned STAT_W = DEV_W + CFG_W + TOP_W;

  typedef enum logic [DEV_W-1:0] {
    BD_SLEEP_PAR = 3'd0,
    BD_SRIO      = 3'd1,
    BD_ETH_CORE  = 3'd2,
    BD_ETH_PKT   = 3'd3,
    BD_PCIE      = 3'd4,
    BD_I2C       = 3'd5,
    BD_SPI       = 3'd6,
    BD_LINK      = 3'd7
  } boot_dev_e;

  // Ordered by priority: a larger value wins.
  typedef enum logic [2:0] {
    RK_NONE   = 3'd0,
    RK_LOCAL  = 3'd1,
    RK_NORMAL = 3'd2,
    RK_FULL   = 3'd3,
    RK_POR    = 3'd4
  } rst_kind_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 13,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/reset_tracker.sv
module reset_tracker
  import boot_strap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_req_i,
  input  logic              full_req_i,
  input  logic              sys_req_i,
  input  logic              core_req_i,
  input  logic              hib_i,
  input  logic [ADDR_W-1:0] hib_addr_i,
  output logic              capture_o,
  output logic              start_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] resume_addr_o
);
  rst_kind_e cur_kind, pend_q, pend_d;
  logic any_req, release_w, boots_w;

  always_comb begin
    if (por_req_i)       cur_kind = RK_POR;
    else if (full_req_i) cur_kind = RK_FULL;
    else if (sys_req_i)  cur_kind = RK_NORMAL;
    else if (core_req_i) cur_kind = RK_LOCAL;
    else                 cur_kind = RK_NONE;
  end

  assign any_req   = (cur_kind != RK_NONE);
  assign release_w = !any_req && (pend_q != RK_NONE);
  assign boots_w   = release_w && (pend_q != RK_LOCAL);
  assign capture_o = release_w && ((pend_q == RK_POR) || (pend_q == RK_FULL)) && !hib_i;

  always_comb begin
    pend_d = RK_NONE;
    if (any_req) pend_d = (cur_kind > pend_q) ? cur_kind : pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= RK_NONE;
      start_o       <= 1'b0;
      resume_o      <= 1'b0;
      resume_addr_o <= '0;
    end else begin
      pend_q   <= pend_d;
      start_o  <= boots_w && !hib_i;
      resume_o <= boots_w && hib_i;
      if (boots_w && hib_i) resume_addr_o <= hib_addr_i;
    end
  end

  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_resume_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  assert_local_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_w && pend_q == RK_LOCAL) |=> (!start_o && !resume_o));
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && resume_o));
  assert_no_cap_hib_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hib_i |-> !capture_o);
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import boot_strap_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  output logic [DEV_W-1:0]  boot_dev_o,
  output logic [CFG_W-1:0]  dev_cfg_o,
  output logic [TOP_W-1:0]  pll_sel_o,
  output logic [TOP_W-1:0]  ext_cfg_o,
  output logic              pll_bypass_o
);
  localparam int unsigned CFG_LSB = DEV_W;
  localparam int unsigned TOP_LSB = DEV_W + CFG_W;

  logic [TOP_W-1:0] top_w;

  assign boot_dev_o   = status_i[DEV_W-1:0];
  assign dev_cfg_o    = status_i[CFG_LSB +: CFG_W];
  assign top_w        = status_i[TOP_LSB +: TOP_W];
  assign pll_bypass_o = (boot_dev_o == BD_I2C) || (boot_dev_o == BD_SPI);
  assign pll_sel_o    = pll_bypass_o ? '0 : top_w;
  assign ext_cfg_o    = pll_bypass_o ? top_w : '0;

  always_comb begin
    assert_field_split_R8: assert ((pll_sel_o == '0) || (ext_cfg_o == '0));
  end
endmodule

// File: rtl/boot_strap_seq.sv
module boot_strap_seq
  import boot_strap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [12:0]       strap_i,
  input  logic              por_req_i,
  input  logic              full_req_i,
  input  logic              sys_req_i,
  input  logic              core_req_i,
  input  logic              hib_i,
  input  logic [ADDR_W-1:0] hib_addr_i,
  output logic [12:0]       status_o,
  output logic [2:0]        boot_dev_o,
  output logic [6:0]        dev_cfg_o,
  output logic [2:0]        pll_sel_o,
  output logic [2:0]        ext_cfg_o,
  output logic              pll_bypass_o,
  output logic              boot_start_o,
  output logic              resume_o,
  output logic [ADDR_W-1:0] resume_addr_o
);
  logic [STAT_W-1:0] strap_sync_w, status_q;
  logic              capture_w;

  strap_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strap_i),
    .q_o   (strap_sync_w)
  );

  reset_tracker #(.ADDR_W(ADDR_W)) i_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_req_i    (por_req_i),
    .full_req_i   (full_req_i),
    .sys_req_i    (sys_req_i),
    .core_req_i   (core_req_i),
    .hib_i        (hib_i),
    .hib_addr_i   (hib_addr_i),
    .capture_o    (capture_w),
    .start_o      (boot_start_o),
    .resume_o     (resume_o),
    .resume_addr_o(resume_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (capture_w) status_q <= strap_sync_w;
  end

  assign status_o = status_q;

  strap_decode i_dec (
    .status_i    (status_q),
    .boot_dev_o  (boot_dev_o),
    .dev_cfg_o   (dev_cfg_o),
    .pll_sel_o   (pll_sel_o),
    .ext_cfg_o   (ext_cfg_o),
    .pll_bypass_o(pll_bypass_o)
  );

  assert_status_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_w |=> $stable(status_q));
  assert_capture_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_w |=> (status_q == $past(strap_sync_w)));
  assert_resume_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_o) |-> (resume_addr_o == $past(hib_addr_i)));
endmodule

// File: tb/test_boot_strap_seq.sv
`timescale 1ns/1ps
module test_boot_strap_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] strap = '0;
  logic [3:0]  req = '0;  // [3]=por [2]=full [1]=normal [0]=local
  logic        hib = 0;
  logic [31:0] hib_addr = '0;
  logic [12:0] status;
  logic [2:0]  dev, pll_sel, ext_cfg;
  logic [6:0]  cfg;
  logic        bypass, start, resume;
  logic [31:0] raddr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  boot_strap_seq i_boot_strap_seq (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .por_req_i(req[3]), .full_req_i(req[2]), .sys_req_i(req[1]), .core_req_i(req[0]),
    .hib_i(hib), .hib_addr_i(hib_addr),
    .status_o(status), .boot_dev_o(dev), .dev_cfg_o(cfg), .pll_sel_o(pll_sel),
    .ext_cfg_o(ext_cfg), .pll_bypass_o(bypass), .boot_start_o(start),
    .resume_o(resume), .resume_addr_o(raddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Hold mask, release on a negedge; s1/r1 sampled after the release edge, s2/r2 one cycle later.
  task automatic run_req(input logic [3:0] mask, input int hold,
                         output logic s1, output logic r1, output logic s2, output logic r2);
    @(negedge clk) req = mask;
    repeat (hold) @(negedge clk);
    req = '0;
    @(negedge clk);
    s1 = start; r1 = resume;
    @(negedge clk);
    s2 = start; r2 = resume;
  endtask

  task automatic set_strap(input logic [12:0] v);
    @(negedge clk) strap = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R11 status", status, 0);
    chk("R11 start", start, 0);
    chk("R11 resume", resume, 0);
    chk("R11 addr", raddr, 0);
  endtask

  task automatic t_por_capture();
    logic s1, r1, s2, r2;
    logic [12:0] v = {3'b101, 7'h55, 3'd1};
    set_strap(v);
    run_req(4'b1000, 4, s1, r1, s2, r2);
    chk("R2 status", status, v);
    chk("R6 start rise", s1, 1);
    chk("R6 start single", s2, 0);
    chk("R1 dev", dev, 3'd1);
    chk("R1 cfg", cfg, 7'h55);
    chk("R1 pll_sel", pll_sel, 3'b101);
  endtask

  task automatic t_normal_keep();
    logic s1, r1, s2, r2;
    logic [12:0] old = status;
    set_strap({3'b010, 7'h0F, 3'd4});
    run_req(4'b0010, 3, s1, r1, s2, r2);
    chk("R4 start", s1, 1);
    chk("R4 status kept", status, old);
    chk("R6 single", s2, 0);
  endtask

  task automatic t_full_capture();
    logic s1, r1, s2, r2;
    logic [12:0] v = {3'b011, 7'h2A, 3'd2};
    set_strap(v);
    run_req(4'b0100, 5, s1, r1, s2, r2);
    chk("R3 status", status, v);
    chk("R3 start", s1, 1);
  endtask

  task automatic t_local();
    logic s1, r1, s2, r2;
    logic [12:0] old = status;
    set_strap({3'b111, 7'h7F, 3'd7});
    run_req(4'b0001, 4, s1, r1, s2, r2);
    chk("R5 status", status, old);
    chk("R5 start", s1 | s2, 0);
    chk("R5 resume", r1 | r2, 0);
  endtask

  task automatic t_dev_sweep();
    for (int d = 0; d < 8; d++) begin
      logic s1, r1, s2, r2;
      logic byp = (d == 5) || (d == 6);
      set_strap({3'b110, 7'h11, d[2:0]});
      run_req(4'b1000, 3, s1, r1, s2, r2);
      chk("R7 bypass", bypass, byp);
      chk("R8 pll_sel", pll_sel, byp ? 3'b000 : 3'b110);
      chk("R8 ext_cfg", ext_cfg, byp ? 3'b110 : 3'b000);
    end
  endtask

  task automatic t_hib();
    logic s1, r1, s2, r2;
    logic [12:0] old = status;
    hib = 1; hib_addr = 32'hCAFE_1234;
    set_strap({3'b001, 7'h33, 3'd3});
    run_req(4'b1000, 3, s1, r1, s2, r2);
    chk("R9 resume", r1, 1);
    chk("R9 resume single", r2, 0);
    chk("R9 no start", s1 | s2, 0);
    chk("R9 addr", raddr, 32'hCAFE_1234);
    chk("R9 status kept", status, old);
    hib = 0;
  endtask

  task automatic t_priority();
    logic s1, r1, s2, r2;
    logic [12:0] old = status;
    logic [12:0] v = {3'b100, 7'h44, 3'd0};
    set_strap(v);
    run_req(4'b0011, 3, s1, r1, s2, r2);
    chk("R10 local+normal start", s1, 1);
    chk("R10 local+normal no capture", status, old);
    run_req(4'b0110, 3, s1, r1, s2, r2);
    chk("R10 full+normal capture", status, v);
    v = {3'b001, 7'h05, 3'd6};
    set_strap(v);
    // power-on first, then normal alone before release: power-on still governs
    @(negedge clk) req = 4'b1000;
    repeat (2) @(negedge clk);
    req = 4'b0010;
    repeat (2) @(negedge clk);
    req = '0;
    @(negedge clk);
    chk("R10 staggered capture", status, v);
    chk("R10 staggered start", start, 1);
  endtask

  task automatic t_no_release();
    logic [12:0] old = status;
    set_strap(13'h1ABC);
    repeat (5) @(negedge clk);
    chk("R12 status", status, old);
    chk("R12 start", start, 0);
  endtask

  task automatic t_async_reset();
    @(negedge clk) rst_n = 0;
    #2;
    chk("R11 status clr", status, 0);
    chk("R11 addr clr", raddr, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_por_capture();
    t_normal_keep();
    t_full_capture();
    t_local();
    t_dev_sweep();
    t_hib();
    t_priority();
    t_no_release();
    t_async_reset();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule